// File: doc/BRIEF.md
# Seven-to-one parallel-to-serial link transmitter

This block turns a wide parallel word into a narrow serial link. On every rising edge of a word clock it takes a 28-bit word and splits it into four serial data lanes. Each lane sends seven bits in every word period. A fifth lane carries a forwarded clock with the same period as the word clock, so a receiver can recover the word boundary. The bit clock runs seven times faster than the word clock, is phase-aligned with it, and comes from outside the block. All logic runs on that bit clock. The word clock is sampled as a signal, and its rising edge is found at bit-clock resolution.

An active-low power-down input, `pd_n`, releases all five lanes. Each lane has an output-enable next to its serial value, so a pad ring can build a tri-state driver from the pair. After power-down is released the lanes are driven but held idle at zero for a lock-settle interval. That interval is a count of `LOCK_CYCLES` bit-clock cycles, and it stands in for the transmitter PLL settling.

A three-state controller sequences the link:
- `ST_OFF` lasts through reset and power-down.
- `ST_SETTLE` is the lock wait, with the lanes driven but idle.
- `ST_RUN` carries data.

Its transitions are:
- enable (`ST_OFF` to `ST_SETTLE`), when power-down is seen released at a bit-clock edge.
- lock (`ST_SETTLE` to `ST_RUN`), at a word-clock rising edge once the wait has elapsed.
- drop (`ST_SETTLE` or `ST_RUN` to `ST_OFF`), when power-down is seen asserted.

Top module: `link_serializer`

## Requirements
- R1: While `rst_n` is low, and after reset until power-down is released, every bit of `lane_oe` and `lane_q` is 0. Asserting `rst_n` low clears them without waiting for a clock edge.
- R2: A word is taken from `din` at the bit-clock edge where `word_clk` is first seen high after being seen low. Changes on `din` at any other edge have no effect on what is sent.
- R3: Data lane k (k = 0 to 3, `lane_q[k]`) carries `din` bits 7k through 7k+6, lowest-numbered bit first. Each bit holds for exactly one bit-clock cycle, which is one seventh of the word period.
- R4: A word sampled at word-clock rise n is sent in the seven bit-clock cycles that begin at rise n+1. Its first bit is visible right after that edge, one word period after sampling.
- R5: Lane 4 (`lane_q[4]`) is the forwarded clock. In the same seven cycles as each data word it sends 1,1,0,0,0,1,1, so it has one rising edge per word period.
- R6: While `pd_n` is low, all of `lane_oe` is 0 and all of `lane_q` is 0. `lane_oe` falls as soon as `pd_n` falls, without waiting for a clock edge.
- R7: From the bit-clock edge that first sees `pd_n` high until data starts, all five `lane_oe` bits are 1 and all `lane_q` bits are 0. The five enables are always equal.
- R8: Data starts (`ST_RUN`) at the first word-clock rise whose distance from the enabling edge is at least `LOCK_CYCLES` bit-clock cycles; a rise at exactly `LOCK_CYCLES` qualifies. Any power-down restarts this count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock, seven times the word rate; all logic is on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down; low releases every lane |
| word_clk | input | 1 | Word clock, phase-aligned to bit_clk; its rising edge samples din |
| din | input | LANES*BITS (28) | Parallel word to send |
| lane_q | output | LANES+1 (5) | Serial values; bits 0 to 3 are data lanes, bit 4 is the forwarded clock |
| lane_oe | output | LANES+1 (5) | Per-lane drive enable; 0 means high impedance |

## Verification
A wrong controller state shows at the ports within one bit-clock cycle. A stray `ST_OFF` drops all `lane_oe` bits. A stray `ST_SETTLE` flattens `lane_q` while the enables stay high. A premature `ST_RUN` puts data on the lanes a whole word period early, and a late one withholds data for a word period. A slipped word boundary or a mis-loaded shift register corrupts the forwarded clock pattern and the lane bit order within the same word period. The bench therefore compares every bit of all five lanes across whole word periods.

// File: rtl/link_ser_pkg.sv
package link_ser_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_RUN    = 2'd2
    } link_state_t;

    // Forwarded-clock slot pattern, index 0 sent first: high for the first
    // and last quarter of the word period, low in between (1100011 for 7).
    function automatic logic [63:0] fwd_pattern(input int width);
        logic [63:0] pat;
        int          hi;
        pat = '0;
        hi  = (width + 1) / 4;
        for (int i = 0; i < width; i++) begin
            pat[i] = (i < hi) || (i >= width - hi);
        end
        return pat;
    endfunction

endpackage

// File: rtl/link_lock_fsm.sv
module link_lock_fsm
    import link_ser_pkg::*;
#(
    parameter int LOCK_CYCLES = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pd_n,
    input  logic        word_rise,
    output link_state_t state,
    output logic        drive_en,
    output logic        run_en
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);

    link_state_t      state_nx;
    logic [CW-1:0]    wait_cnt;
    logic             wait_done;

    assign wait_done = (wait_cnt >= CW'(LOCK_CYCLES));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // lock-settle counter: reads 1 on the edge after enable, then one per cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (state == ST_OFF) begin
            wait_cnt <= CW'(1);
        end else if (!wait_done) begin
            wait_cnt <= wait_cnt + CW'(1);
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:    if (pd_n) state_nx = ST_SETTLE;
            ST_SETTLE: if (!pd_n) state_nx = ST_OFF;
                       else if (word_rise && wait_done) state_nx = ST_RUN;
            ST_RUN:    if (!pd_n) state_nx = ST_OFF;
            default:   state_nx = ST_OFF;
        endcase
    end

    // outputs; pd_n gates them directly so release needs no clock edge
    always_comb begin
        drive_en = 1'b0;
        run_en   = 1'b0;
        unique case (state)
            ST_OFF:    begin drive_en = 1'b0; run_en = 1'b0; end
            ST_SETTLE: begin drive_en = pd_n; run_en = 1'b0; end
            ST_RUN:    begin drive_en = pd_n; run_en = pd_n; end
            default:   begin drive_en = 1'b0; run_en = 1'b0; end
        endcase
    end

endmodule

// File: rtl/word_edge_capture.sv
module word_edge_capture #(
    parameter int DW = 28
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          word_clk,
    input  logic [DW-1:0] din,
    output logic          word_rise,
    output logic [DW-1:0] word_q
);
    logic wclk_q;

    assign word_rise = word_clk && !wclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wclk_q <= 1'b0;
            word_q <= '0;
        end else begin
            wclk_q <= word_clk;
            if (word_rise) word_q <= din;
        end
    end

endmodule

// File: rtl/lane_shifter.sv
module lane_shifter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] par_in,
    output logic         ser
);
    logic [W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sh <= '0;
        else if (load) sh <= par_in;
        else           sh <= {1'b0, sh[W-1:1]};
    end

    assign ser = sh[0];

endmodule

// File: rtl/link_serializer.sv
module link_serializer
    import link_ser_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int BITS        = 7,
    parameter int LOCK_CYCLES = 1000
) (
    input  logic                   bit_clk,
    input  logic                   rst_n,
    input  logic                   pd_n,
    input  logic                   word_clk,
    input  logic [LANES*BITS-1:0]  din,
    output logic [LANES:0]         lane_q,
    output logic [LANES:0]         lane_oe
);
    localparam int DW = LANES * BITS;
    localparam logic [BITS-1:0] FWD_PAT = BITS'(fwd_pattern(BITS));

    link_state_t   state;
    logic          drive_en;
    logic          run_en;
    logic          word_rise;
    logic [DW-1:0] word_q;
    logic [LANES:0] ser;

    word_edge_capture #(.DW(DW)) u_cap (
        .clk       (bit_clk),
        .rst_n     (rst_n),
        .word_clk  (word_clk),
        .din       (din),
        .word_rise (word_rise),
        .word_q    (word_q)
    );

    link_lock_fsm #(.LOCK_CYCLES(LOCK_CYCLES)) u_fsm (
        .clk       (bit_clk),
        .rst_n     (rst_n),
        .pd_n      (pd_n),
        .word_rise (word_rise),
        .state     (state),
        .drive_en  (drive_en),
        .run_en    (run_en)
    );

    for (genvar k = 0; k <= LANES; k++) begin : g_lane
        logic [BITS-1:0] slot_bits;
        if (k < LANES) begin : g_data
            assign slot_bits = word_q[k*BITS +: BITS];
        end else begin : g_fwd
            assign slot_bits = FWD_PAT;
        end
        lane_shifter #(.W(BITS)) u_sh (
            .clk    (bit_clk),
            .rst_n  (rst_n),
            .load   (word_rise),
            .par_in (slot_bits),
            .ser    (ser[k])
        );
        assign lane_q[k]  = run_en & ser[k];
        assign lane_oe[k] = drive_en;
    end

endmodule

// File: rtl/link_ser_checker.sv
module link_ser_checker
    import link_ser_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int BITS        = 7,
    parameter int LOCK_CYCLES = 1000
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  pd_n,
    input logic                  run_en,
    input logic                  word_rise,
    input logic [LANES*BITS-1:0] word_q,
    input logic [LANES:0]        lane_q,
    input logic [LANES:0]        lane_oe
);
    localparam int SW = $clog2(BITS);
    localparam int CW = $clog2(LOCK_CYCLES + 2);
    localparam logic [BITS-1:0] FWD_PAT = BITS'(fwd_pattern(BITS));

    logic [LANES*BITS-1:0] ref_w;
    logic [SW-1:0]         slot;
    logic [CW-1:0]         en_cnt;
    logic [LANES:0]        exp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_w <= '0;
            slot  <= '0;
        end else if (word_rise) begin
            ref_w <= word_q;
            slot  <= '0;
        end else if (slot != SW'(BITS - 1)) begin
            slot  <= slot + SW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          en_cnt <= '0;
        else if (!pd_n)                      en_cnt <= '0;
        else if (en_cnt <= CW'(LOCK_CYCLES)) en_cnt <= en_cnt + CW'(1);
    end

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            exp_q[k] = ref_w[k*BITS + int'(slot)];
        end
        exp_q[LANES] = FWD_PAT[slot];
    end

    AST_PD_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |-> (lane_oe == '0 && lane_q == '0)); // R6

    AST_OE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_oe == '0) || (&lane_oe)); // R7

    AST_SETTLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_oe[0] && !run_en) |-> (lane_q == '0)); // R7

    AST_LOCK_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_en) |-> (en_cnt > CW'(LOCK_CYCLES))); // R8

    AST_LANE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |-> (lane_q == exp_q)); // R3 R4 R5

endmodule

bind link_serializer link_ser_checker #(
    .LANES       (LANES),
    .BITS        (BITS),
    .LOCK_CYCLES (LOCK_CYCLES)
) u_chk (
    .clk       (bit_clk),
    .rst_n     (rst_n),
    .pd_n      (pd_n),
    .run_en    (run_en),
    .word_rise (word_rise),
    .word_q    (word_q),
    .lane_q    (lane_q),
    .lane_oe   (lane_oe)
);

// File: tb/tb_link_serializer.sv
module tb_link_serializer;
    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 4;
    localparam int BITS       = 7;
    localparam int LOCK       = 20;
    localparam int NL         = LANES + 1;
    localparam int DW         = LANES * BITS;
    localparam int IMG        = NL * BITS;
    localparam logic [BITS-1:0] FWD = 7'b1100011;
    localparam logic [IMG-1:0]  ALL_ON = '1;

    localparam logic [DW-1:0] TAB [8] = '{
        28'h0000000, 28'hFFFFFFF, 28'h5555555, 28'hAAAAAAA,
        28'h0000001, 28'h8000000, 28'h1234567, 28'hC3A5F0E
    };

    logic bit_clk  = 1'b0;
    logic rst_n    = 1'b0;
    logic pd_n     = 1'b0;
    logic word_clk = 1'b0;
    logic [DW-1:0] din = '0;
    logic [NL-1:0] lane_q;
    logic [NL-1:0] lane_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic [IMG-1:0] q_img;
    logic [IMG-1:0] oe_img;
    logic [NL-1:0]  imm_oe;

    link_serializer #(.LANES(LANES), .BITS(BITS), .LOCK_CYCLES(LOCK)) dut (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .pd_n    (pd_n),
        .word_clk(word_clk),
        .din     (din),
        .lane_q  (lane_q),
        .lane_oe (lane_oe)
    );

    always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

    task automatic check(input string tag, input logic [IMG-1:0] act, input logic [IMG-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // one word period: d sampled at the rise, d_late on the other edges;
    // pd_n set to pd_val before the edge of phase pd_phase
    task automatic word_period(input logic [DW-1:0] d, input logic [DW-1:0] d_late,
                               input int pd_phase, input logic pd_val);
        for (int p = 0; p < BITS; p++) begin
            @(negedge bit_clk);
            word_clk = (p < 4);
            din      = (p == 0) ? d : d_late;
            if (p == pd_phase) begin
                pd_n = pd_val;
                #1 imm_oe = lane_oe;
            end
            @(posedge bit_clk);
            #(CLK_PERIOD/4);
            for (int k = 0; k < NL; k++) begin
                q_img[k*BITS + p]  = lane_q[k];
                oe_img[k*BITS + p] = lane_oe[k];
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [IMG-1:0] mask;
        // R1: reset state
        word_period(28'hABCDEF1, 28'h0, -1, 1'b0);
        check("R1 reset oe", oe_img, '0);
        check("R1 reset q", q_img, '0);
        rst_n = 1'b1;
        // R6: power-down held after reset
        word_period(28'h1111111, 28'h2222222, -1, 1'b0);
        check("R6 powered-down oe", oe_img, '0);
        check("R6 powered-down q", q_img, '0);

        // table walk: enable at the rise of period 0, LOCK=20 -> data from period 3
        for (int i = 0; i < 8; i++) begin
            word_period(TAB[i], ~TAB[i], (i == 0) ? 0 : -1, 1'b1);
            check("R7 settle/run oe", oe_img, ALL_ON);
            if (i < 3) check("R7 R8 idle during lock wait", q_img, '0);
            else       check("R2 R3 R4 R5 lane image", q_img, {FWD, TAB[i-1]});
        end

        // R6: power-down in the middle of a word (phase 3)
        word_period(28'h0F0F0F0, 28'h0, 3, 1'b0);
        check("R6 immediate release", {{(IMG-NL){1'b0}}, imm_oe}, '0);
        mask = '0;
        for (int k = 0; k < NL; k++)
            for (int p = 0; p < 3; p++) mask[k*BITS + p] = 1'b1;
        check("R6 R4 partial word then idle", q_img, {FWD, TAB[7]} & mask);
        check("R6 oe drop mid word", oe_img, mask);

        // R8: re-enable at phase 1 -> rises at distances 6, 13, 20
        word_period(28'h3333333, 28'h0, 1, 1'b1);
        check("R7 re-enable q idle", q_img, '0);
        word_period(28'h6543210, 28'h0, -1, 1'b1);
        check("R8 restart distance 6 idle", q_img, '0);
        word_period(28'h9ABCDEF, 28'h0, -1, 1'b1);
        check("R8 distance 13 idle", q_img, '0);
        word_period(28'h5A5A5A5, 28'h0, -1, 1'b1);
        check("R8 run at exactly LOCK", q_img, {FWD, 28'h9ABCDEF});
        word_period(28'h0, 28'hFFFFFFF, -1, 1'b1);
        check("R2 R3 R4 following word", q_img, {FWD, 28'h5A5A5A5});

        // R1: asynchronous reset while running
        @(negedge bit_clk);
        rst_n = 1'b0;
        #1;
        check("R1 async reset oe", {{(IMG-NL){1'b0}}, lane_oe}, '0);
        check("R1 async reset q", {{(IMG-NL){1'b0}}, lane_q}, '0);

        summary();
        $finish;
    end

endmodule